// File: doc/BRIEF.md
# Isochronous OUT Ping-Pong Receive Buffer

This block handles the receive side of one isochronous OUT endpoint of a USB device. It takes decoded token events (OUT and start-of-frame) from an upstream serial interface engine. It also takes the data packet from that engine as a start marker with a DATA0 flag, a byte stream and an end marker carrying the CRC verdict. Payload is stored in one of two packet buffers, A and B.

At any moment one buffer has the bus role: it collects the current frame's packet. The other has the CPU role: it holds the previous frame's packet. Every start-of-frame token swaps the two roles. The buffer that takes the bus role is wiped at that swap, so the CPU always sees data one frame late.

The CPU reads its buffer through a byte port with an auto-incrementing pointer. Alongside that port it sees:
- a byte count for each buffer,
- a ready bit for each buffer,
- a status word,
- the last frame number,
- a one-cycle start-of-frame strobe.

No handshake is produced. After an OUT transaction the controller goes straight back to idle.

Top module: `iso_pingpong_rx`

## Requirements
- R1: After reset: bus_sel is 0 (buffer A has the bus role), buf_ready is 2'b00, size_a, size_b, rx_status and frame_num are 0, sof_pulse is 0 and cpu_rdata is 0.
- R2: A start-of-frame token is tok_valid with tok_kind 2'd2. The cycle after it, sof_pulse is 1 and frame_num equals that token's tok_frame. sof_pulse is 0 in every cycle that does not follow such a token.
- R3: bus_sel inverts in the cycle after each start-of-frame token and holds otherwise. The CPU role always belongs to the other buffer (bus_sel 1 means B has the bus role and A the CPU role). The CPU read pointer returns to 0 at every swap.
- R4: At a swap, buf_ready sets the bit of the buffer that moved to the CPU role and clears the bit of the buffer that moved to the bus role. Bit 0 is A and bit 1 is B.
- R5: The buffer that enters the bus role at a swap has its size set to 0 and all its bytes set to 0.
- R6: An OUT token is tok_valid with tok_kind 2'd1. It is accepted only when tok_addr equals cfg_dev_addr, tok_ep equals cfg_ep_num and cfg_ep_iso is 1. After a rejected token, a following data packet changes neither the sizes nor rx_status.
- R7: After an accepted OUT, a data packet whose pkt_is_data0 is 0 is ignored: the controller returns to idle and stores nothing.
- R8: An accepted DATA0 packet is handled as follows. Its bytes are written in arrival order from offset 0 of the bus-role buffer. That buffer's size reads 0 from the packet start. At pkt_end, the size becomes the count of stored bytes. The size of the CPU-role buffer does not change between swaps.
- R9: At pkt_end, rx_status becomes {overflow, rx_err, data_in}. This is 3'b001 for a good CRC and 3'b010 for a bad one, with bit 2 added for overflow. The bytes and the size are kept even on a CRC error. rx_status holds until the next completed packet.
- R10: Each buffer holds at most 64 bytes. Bytes beyond that are dropped, the size stays 64, and rx_status bit 2 is set at pkt_end.
- R11: cpu_rdata shows the byte of the CPU-role buffer at the read pointer. Each cycle with cpu_rd high advances the pointer by one, visible in the next cycle, and the pointer wraps from 63 to 0.
- R12: If a start-of-frame token arrives while a packet is being received, the packet is discarded. The buffer handed to the CPU shows size 0, and bytes or pkt_end that follow without a new accepted OUT are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dev_addr | input | 7 | Device address the endpoint answers to |
| cfg_ep_num | input | 4 | Endpoint number |
| cfg_ep_iso | input | 1 | 1 when the endpoint is configured isochronous |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | 2'd1 OUT, 2'd2 start-of-frame, others ignored |
| tok_addr | input | 7 | Address field of an OUT token |
| tok_ep | input | 4 | Endpoint field of an OUT token |
| tok_frame | input | 11 | Frame number of a start-of-frame token |
| pkt_start | input | 1 | Data packet PID received |
| pkt_is_data0 | input | 1 | The PID at pkt_start is DATA0 |
| rx_byte_valid | input | 1 | A payload byte is present |
| rx_byte | input | 8 | Payload byte |
| pkt_end | input | 1 | End of data packet |
| pkt_crc_ok | input | 1 | CRC verdict at pkt_end |
| cpu_rd | input | 1 | Advance the CPU read pointer |
| cpu_rdata | output | 8 | Byte at the read pointer of the CPU-role buffer |
| bus_sel | output | 1 | Buffer in the bus role (0 A, 1 B) |
| buf_ready | output | 2 | Per-buffer data-ready bits |
| size_a | output | 7 | Byte count of buffer A |
| size_b | output | 7 | Byte count of buffer B |
| rx_status | output | 3 | {overflow, rx_err, data_in} of the last packet |
| frame_num | output | 11 | Last received frame number |
| sof_pulse | output | 1 | One-cycle start-of-frame strobe |

## Verification
Suppose the role flag drifted from the start-of-frame tokens. bus_sel and buf_ready would then disagree with the token history in the very next cycle. In the same cycle, cpu_rdata would start returning bytes of the wrong buffer. A stuck receive state or byte counter would show up at the next pkt_end, as a wrong size or status. A clear that did not happen, or a pointer that failed to reset, would only appear when the CPU reads a stale byte, which can be a whole frame later. The bench therefore reads past the valid count after a buffer has been reused.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } rx_state_e;

    localparam logic [1:0] TOK_OUT = 2'd1;
    localparam logic [1:0] TOK_SOF = 2'd2;

    typedef struct packed {
        logic ovf;
        logic rx_err;
        logic data_in;
    } rx_status_t;

endpackage

// File: rtl/iso_rx_ctrl.sv
module iso_rx_ctrl
    import iso_rx_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int EP_W      = 4,
    parameter int BUF_BYTES = 64,
    localparam int PTR_W    = $clog2(BUF_BYTES),
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_dev_addr,
    input  logic [EP_W-1:0]   cfg_ep_num,
    input  logic              cfg_ep_iso,
    input  logic              tok_valid,
    input  logic [1:0]        tok_kind,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              pkt_start,
    input  logic              pkt_is_data0,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              pkt_end,
    input  logic              pkt_crc_ok,
    output logic              sof_hit,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [7:0]        wr_data,
    output logic              pkt_begin,
    output logic              pkt_done,
    output logic [CNT_W-1:0]  done_cnt,
    output rx_status_t        status
);

    typedef struct packed {
        rx_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        rx_status_t       status;
    } ctrl_t;

    ctrl_t q, d;
    logic  out_hit;
    logic  tok_ok;

    always_comb begin
        sof_hit   = tok_valid && (tok_kind == TOK_SOF);
        out_hit   = tok_valid && (tok_kind == TOK_OUT);
        tok_ok    = out_hit && (tok_addr == cfg_dev_addr) &&
                    (tok_ep == cfg_ep_num) && cfg_ep_iso;
        d         = q;
        wr_en     = 1'b0;
        wr_idx    = q.cnt[PTR_W-1:0];
        wr_data   = rx_byte;
        pkt_begin = 1'b0;
        pkt_done  = 1'b0;
        done_cnt  = q.cnt;
        if (sof_hit) begin
            // frame boundary abandons any transaction in flight
            d.state = ST_IDLE;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (out_hit) d.state = tok_ok ? ST_WAIT : ST_IDLE;
                end
                ST_WAIT: begin
                    if (out_hit) begin
                        d.state = tok_ok ? ST_WAIT : ST_IDLE;
                    end else if (pkt_start) begin
                        if (pkt_is_data0) begin
                            d.state   = ST_RECV;
                            d.cnt     = '0;
                            d.ovf     = 1'b0;
                            pkt_begin = 1'b1;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_RECV: begin
                    if (pkt_end) begin
                        d.status.ovf     = q.ovf;
                        d.status.rx_err  = !pkt_crc_ok;
                        d.status.data_in = pkt_crc_ok;
                        pkt_done         = 1'b1;
                        d.state          = ST_IDLE;
                    end else if (rx_byte_valid) begin
                        if (q.cnt < CNT_W'(BUF_BYTES)) begin
                            wr_en = 1'b1;
                            d.cnt = q.cnt + 1'b1;
                        end else begin
                            d.ovf = 1'b1;
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
        status = q.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, ovf: 1'b0, status: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/iso_pkt_buf.sv
module iso_pkt_buf #(
    parameter int BUF_BYTES = 64,
    localparam int PTR_W    = $clog2(BUF_BYTES),
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             size_clr,
    input  logic             size_we,
    input  logic [CNT_W-1:0] size_val,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] size
);

    typedef struct packed {
        logic [BUF_BYTES-1:0][7:0] mem;
        logic [CNT_W-1:0]          size;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (size_clr) d.size = '0;
            if (wr_en)    d.mem[wr_idx] = wr_data;
            if (size_we)  d.size = size_val;
        end
        rd_data = q.mem[rd_idx];
        size    = q.size;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/iso_pingpong_rx.sv
module iso_pingpong_rx
    import iso_rx_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int EP_W      = 4,
    parameter int FRAME_W   = 11,
    parameter int BUF_BYTES = 64,
    localparam int PTR_W    = $clog2(BUF_BYTES),
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_dev_addr,
    input  logic [EP_W-1:0]    cfg_ep_num,
    input  logic               cfg_ep_iso,
    input  logic               tok_valid,
    input  logic [1:0]         tok_kind,
    input  logic [ADDR_W-1:0]  tok_addr,
    input  logic [EP_W-1:0]    tok_ep,
    input  logic [FRAME_W-1:0] tok_frame,
    input  logic               pkt_start,
    input  logic               pkt_is_data0,
    input  logic               rx_byte_valid,
    input  logic [7:0]         rx_byte,
    input  logic               pkt_end,
    input  logic               pkt_crc_ok,
    input  logic               cpu_rd,
    output logic [7:0]         cpu_rdata,
    output logic               bus_sel,
    output logic [1:0]         buf_ready,
    output logic [CNT_W-1:0]   size_a,
    output logic [CNT_W-1:0]   size_b,
    output logic [2:0]         rx_status,
    output logic [FRAME_W-1:0] frame_num,
    output logic               sof_pulse
);

    typedef struct packed {
        logic               bus_sel;
        logic [1:0]         ready;
        logic [FRAME_W-1:0] frame;
        logic               sof;
        logic [PTR_W-1:0]   ptr;
    } top_t;

    top_t q, d;

    logic             sof_hit;
    logic             ctl_wr_en;
    logic [PTR_W-1:0] ctl_wr_idx;
    logic [7:0]       ctl_wr_data;
    logic             ctl_begin;
    logic             ctl_done;
    logic [CNT_W-1:0] ctl_cnt;
    rx_status_t       ctl_status;

    logic [7:0]       buf_rd   [2];
    logic [CNT_W-1:0] buf_size [2];

    iso_rx_ctrl #(
        .ADDR_W    (ADDR_W),
        .EP_W      (EP_W),
        .BUF_BYTES (BUF_BYTES)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_dev_addr  (cfg_dev_addr),
        .cfg_ep_num    (cfg_ep_num),
        .cfg_ep_iso    (cfg_ep_iso),
        .tok_valid     (tok_valid),
        .tok_kind      (tok_kind),
        .tok_addr      (tok_addr),
        .tok_ep        (tok_ep),
        .pkt_start     (pkt_start),
        .pkt_is_data0  (pkt_is_data0),
        .rx_byte_valid (rx_byte_valid),
        .rx_byte       (rx_byte),
        .pkt_end       (pkt_end),
        .pkt_crc_ok    (pkt_crc_ok),
        .sof_hit       (sof_hit),
        .wr_en         (ctl_wr_en),
        .wr_idx        (ctl_wr_idx),
        .wr_data       (ctl_wr_data),
        .pkt_begin     (ctl_begin),
        .pkt_done      (ctl_done),
        .done_cnt      (ctl_cnt),
        .status        (ctl_status)
    );

    for (genvar i = 0; i < 2; i++) begin : g_buf
        logic is_bus;
        assign is_bus = (q.bus_sel == 1'(i));
        iso_pkt_buf #(
            .BUF_BYTES (BUF_BYTES)
        ) u_buf (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (sof_hit && !is_bus),
            .wr_en    (ctl_wr_en && is_bus),
            .wr_idx   (ctl_wr_idx),
            .wr_data  (ctl_wr_data),
            .size_clr (ctl_begin && is_bus),
            .size_we  (ctl_done && is_bus),
            .size_val (ctl_cnt),
            .rd_idx   (q.ptr),
            .rd_data  (buf_rd[i]),
            .size     (buf_size[i])
        );
    end

    always_comb begin
        d     = q;
        d.sof = 1'b0;
        if (sof_hit) begin
            d.frame             = tok_frame;
            d.sof               = 1'b1;
            d.bus_sel           = !q.bus_sel;
            d.ready[q.bus_sel]  = 1'b1;
            d.ready[~q.bus_sel] = 1'b0;
            d.ptr               = '0;
        end else if (cpu_rd) begin
            d.ptr = q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_rdata = q.bus_sel ? buf_rd[0] : buf_rd[1];
    assign bus_sel   = q.bus_sel;
    assign buf_ready = q.ready;
    assign size_a    = buf_size[0];
    assign size_b    = buf_size[1];
    assign rx_status = ctl_status;
    assign frame_num = q.frame;
    assign sof_pulse = q.sof;

endmodule

// File: rtl/iso_rx_chk.sv
module iso_rx_chk
    import iso_rx_pkg::*;
#(
    parameter int FRAME_W   = 11,
    parameter int BUF_BYTES = 64,
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tok_valid,
    input logic [1:0]         tok_kind,
    input logic [FRAME_W-1:0] tok_frame,
    input logic               bus_sel,
    input logic [1:0]         buf_ready,
    input logic [CNT_W-1:0]   size_a,
    input logic [CNT_W-1:0]   size_b,
    input logic [2:0]         rx_status,
    input logic [FRAME_W-1:0] frame_num,
    input logic               sof_pulse
);

    logic sof_tok;
    assign sof_tok = tok_valid && (tok_kind == TOK_SOF);

    p_sof_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_tok |=> (sof_pulse && frame_num == $past(tok_frame)));

    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_tok |=> !sof_pulse);

    p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_tok |=> (bus_sel != $past(bus_sel)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_tok |=> $stable(bus_sel));

    p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_tok |=> (buf_ready == ($past(bus_sel) ? 2'b10 : 2'b01)));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sof_tok |=> ((bus_sel ? size_b : size_a) == '0));

    p_cpu_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_tok |=> $stable(bus_sel ? size_a : size_b));

    p_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_status[1:0]));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (size_a <= CNT_W'(BUF_BYTES)) && (size_b <= CNT_W'(BUF_BYTES)));

endmodule

bind iso_pingpong_rx iso_rx_chk #(
    .FRAME_W   (FRAME_W),
    .BUF_BYTES (BUF_BYTES)
) u_chk (.*);

// File: tb/iso_pingpong_rx_tb.sv
module iso_pingpong_rx_tb;

    localparam int BUF = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_dev_addr = 7'h2A;
    logic [3:0]  cfg_ep_num = 4'd3;
    logic        cfg_ep_iso = 1'b1;
    logic        tok_valid = 1'b0;
    logic [1:0]  tok_kind = 2'd0;
    logic [6:0]  tok_addr = 7'd0;
    logic [3:0]  tok_ep = 4'd0;
    logic [10:0] tok_frame = 11'd0;
    logic        pkt_start = 1'b0;
    logic        pkt_is_data0 = 1'b0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = 8'd0;
    logic        pkt_end = 1'b0;
    logic        pkt_crc_ok = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        bus_sel;
    logic [1:0]  buf_ready;
    logic [6:0]  size_a;
    logic [6:0]  size_b;
    logic [2:0]  rx_status;
    logic [10:0] frame_num;
    logic        sof_pulse;

    iso_pingpong_rx u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_dev_addr(cfg_dev_addr), .cfg_ep_num(cfg_ep_num), .cfg_ep_iso(cfg_ep_iso),
        .tok_valid(tok_valid), .tok_kind(tok_kind), .tok_addr(tok_addr),
        .tok_ep(tok_ep), .tok_frame(tok_frame),
        .pkt_start(pkt_start), .pkt_is_data0(pkt_is_data0),
        .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
        .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata), .bus_sel(bus_sel), .buf_ready(buf_ready),
        .size_a(size_a), .size_b(size_b), .rx_status(rx_status),
        .frame_num(frame_num), .sof_pulse(sof_pulse)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int wd = 0;
    bit finished = 0;

    // behavioural reference model
    int m_bus, m_status, m_frame, m_sof, m_ptr, m_state, m_cnt, m_ovf;
    int m_ready [2];
    int m_size [2];
    int m_mem [2][BUF];

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bus = 0; m_status = 0; m_frame = 0; m_sof = 0; m_ptr = 0;
            m_state = 0; m_cnt = 0; m_ovf = 0;
            for (int b = 0; b < 2; b++) begin
                m_ready[b] = 0; m_size[b] = 0;
                for (int k = 0; k < BUF; k++) m_mem[b][k] = 0;
            end
        end else begin
            bit tok_good;
            tok_good = (tok_addr == cfg_dev_addr) && (tok_ep == cfg_ep_num) && cfg_ep_iso;
            m_sof = 0;
            if (tok_valid && tok_kind == 2'd2) begin
                int nb;
                nb = 1 - m_bus;
                m_frame = int'(tok_frame);
                m_sof = 1;
                m_ready[m_bus] = 1;
                m_ready[nb] = 0;
                m_size[nb] = 0;
                for (int k = 0; k < BUF; k++) m_mem[nb][k] = 0;
                m_bus = nb;
                m_ptr = 0;
                m_state = 0;
            end else begin
                if (cpu_rd) m_ptr = (m_ptr + 1) % BUF;
                if (m_state == 0) begin
                    if (tok_valid && tok_kind == 2'd1) m_state = tok_good ? 1 : 0;
                end else if (m_state == 1) begin
                    if (tok_valid && tok_kind == 2'd1) m_state = tok_good ? 1 : 0;
                    else if (pkt_start) begin
                        if (pkt_is_data0) begin
                            m_state = 2; m_cnt = 0; m_ovf = 0; m_size[m_bus] = 0;
                        end else m_state = 0;
                    end
                end else begin
                    if (pkt_end) begin
                        m_status = (m_ovf << 2) | (pkt_crc_ok ? 1 : 2);
                        m_size[m_bus] = m_cnt;
                        m_state = 0;
                    end else if (rx_byte_valid) begin
                        if (m_cnt < BUF) begin
                            m_mem[m_bus][m_cnt] = int'(rx_byte);
                            m_cnt++;
                        end else m_ovf = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 bus_sel", int'(bus_sel), m_bus);
            chk("R4 buf_ready", int'(buf_ready), m_ready[1] * 2 + m_ready[0]);
            chk("R8 size_a", int'(size_a), m_size[0]);
            chk("R8 size_b", int'(size_b), m_size[1]);
            chk("R9 rx_status", int'(rx_status), m_status);
            chk("R2 frame_num", int'(frame_num), m_frame);
            chk("R2 sof_pulse", int'(sof_pulse), m_sof);
            chk("R11 cpu_rdata", int'(cpu_rdata), m_mem[1 - m_bus][m_ptr]);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_tok(input logic [1:0] k, input logic [6:0] a,
                            input logic [3:0] e, input logic [10:0] f);
        tok_valid = 1'b1; tok_kind = k; tok_addr = a; tok_ep = e; tok_frame = f;
        tick();
        tok_valid = 1'b0;
    endtask

    task automatic send_bytes(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            rx_byte_valid = 1'b1;
            rx_byte = 8'(base + i);
            tick();
        end
        rx_byte_valid = 1'b0;
    endtask

    task automatic send_end(input logic crc);
        pkt_end = 1'b1; pkt_crc_ok = crc;
        tick();
        pkt_end = 1'b0;
    endtask

    task automatic send_pkt(input logic d0, input int n, input int base, input logic crc);
        pkt_start = 1'b1; pkt_is_data0 = d0;
        tick();
        pkt_start = 1'b0;
        send_bytes(n, base);
        send_end(crc);
    endtask

    task automatic cpu_read(input int n);
        cpu_rd = 1'b1;
        repeat (n) tick();
        cpu_rd = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 bus_sel", int'(bus_sel), 0);
        chk("R1 buf_ready", int'(buf_ready), 0);
        chk("R1 size_a", int'(size_a), 0);
        chk("R1 size_b", int'(size_b), 0);
        chk("R1 rx_status", int'(rx_status), 0);
        chk("R1 frame_num", int'(frame_num), 0);
        chk("R1 sof_pulse", int'(sof_pulse), 0);
        chk("R1 cpu_rdata", int'(cpu_rdata), 0);
        tick();

        send_tok(2'd2, 7'd0, 4'd0, 11'd5);
        chk("R2 strobe", int'(sof_pulse), 1);
        chk("R2 frame", int'(frame_num), 5);
        chk("R3 swap", int'(bus_sel), 1);
        chk("R4 ready", int'(buf_ready), 1);
        tick();
        chk("R2 strobe low", int'(sof_pulse), 0);

        send_tok(2'd1, 7'h2A, 4'd3, 11'd0);
        send_pkt(1'b1, 10, 8'h10, 1'b1);
        chk("R8 size_b", int'(size_b), 10);
        chk("R9 good status", int'(rx_status), 1);

        send_tok(2'd2, 7'd0, 4'd0, 11'd6);
        chk("R4 ready", int'(buf_ready), 2);
        chk("R5 size_a", int'(size_a), 0);
        chk("R11 first", int'(cpu_rdata), 8'h10);
        cpu_read(3);
        chk("R11 step", int'(cpu_rdata), 8'h13);

        send_tok(2'd1, 7'h2B, 4'd3, 11'd0);
        send_pkt(1'b1, 4, 8'h70, 1'b1);
        chk("R6 bad addr size", int'(size_a), 0);
        chk("R6 bad addr status", int'(rx_status), 1);
        send_tok(2'd1, 7'h2A, 4'd4, 11'd0);
        send_pkt(1'b1, 4, 8'h70, 1'b0);
        chk("R6 bad ep size", int'(size_a), 0);
        cfg_ep_iso = 1'b0;
        send_tok(2'd1, 7'h2A, 4'd3, 11'd0);
        send_pkt(1'b1, 4, 8'h70, 1'b0);
        cfg_ep_iso = 1'b1;
        chk("R6 not iso status", int'(rx_status), 1);
        send_tok(2'd1, 7'h2A, 4'd3, 11'd0);
        send_pkt(1'b0, 4, 8'h70, 1'b0);
        chk("R7 data1 size", int'(size_a), 0);
        chk("R7 data1 status", int'(rx_status), 1);

        send_tok(2'd1, 7'h2A, 4'd3, 11'd0);
        send_pkt(1'b1, 70, 8'h40, 1'b0);
        chk("R10 capped size", int'(size_a), 64);
        chk("R10 R9 ovf crc status", int'(rx_status), 6);

        send_tok(2'd2, 7'd0, 4'd0, 11'd7);
        chk("R5 size_b", int'(size_b), 0);
        cpu_read(63);
        chk("R11 last", int'(cpu_rdata), 8'h7F);
        cpu_read(1);
        chk("R11 wrap", int'(cpu_rdata), 8'h40);

        send_tok(2'd1, 7'h2A, 4'd3, 11'd0);
        send_pkt(1'b1, 3, 8'hA0, 1'b1);
        send_tok(2'd2, 7'd0, 4'd0, 11'd8);
        chk("R8 size_b", int'(size_b), 3);
        cpu_read(5);
        chk("R5 stale byte", int'(cpu_rdata), 0);

        send_tok(2'd1, 7'h2A, 4'd3, 11'd0);
        pkt_start = 1'b1; pkt_is_data0 = 1'b1;
        tick();
        pkt_start = 1'b0;
        send_bytes(5, 8'h55);
        send_tok(2'd2, 7'd0, 4'd0, 11'd9);
        chk("R12 size_a", int'(size_a), 0);
        send_bytes(3, 8'h66);
        send_end(1'b0);
        chk("R12 size_b", int'(size_b), 0);
        chk("R12 status", int'(rx_status), 1);

        send_tok(2'd2, 7'd0, 4'd0, 11'd10);
        send_tok(2'd2, 7'd0, 4'd0, 11'd11);
        chk("R2 back-to-back", int'(sof_pulse), 1);
        chk("R3 back-to-back", int'(bus_sel), 1);
        repeat (4) tick();
        summary();
    end

endmodule